// File: doc/BRIEF.md
# Variable-Pulse-Width Bus Idle and Break Detector

This block watches the resolved level of a single-wire variable-pulse-width bus. It tells the local transmitters when they may start a start-of-frame pulse. The bus is passive at logic 0 and active at logic 1. The block resynchronises the bus level into the local clock and times each passive and active run. From those run lengths it derives four things: an end-of-frame flag, an idle (inter-frame separation) flag, a break pulse, and a late-join pulse.

Skewed nodes do not all see the idle condition at the same moment. For that reason, idle is granted in two ways:
- A passive run reaches the full separation time.
- A passive run reaches the end-of-frame minimum, and then another node's rising edge is observed. This grants a one-cycle late-join permission, so the node can still enter the arbitration that the other node has just opened.

An over-long active pulse is a break. The block reports it with a one-cycle pulse, which the local state machines use to return to ready-to-receive. The pulse also raises an arbitration lock. The lock suppresses late-join permission until a full separation time has again been observed.

All times are parameters in clock cycles: `EOF_T`, `IFS_T` (greater than `EOF_T`) and `BRK_T` (at least 2). The block has no data path, so every pin is a plain level or pulse without handshake.

Top module: `vpw_idle_brk_det`

## Requirements
In the requirements below, "sampled at edge k" means the value of `bus_i` at rising clock edge k, and all outputs are registered.
- R1: While `rst_ni` is low, `idle_o`, `eof_o`, `brk_o`, `join_o`, `lock_o` and `sof_ok_o` are all 0.
- R2: Let `bus_i` be sampled 0 at edge k after having been 1, and stay 0. Then `idle_o` becomes 1 after edge k+1+`IFS_T`. A passive run of fewer than `IFS_T` samples never raises it.
- R3: Under the same conditions, `eof_o` becomes 1 after edge k+1+`EOF_T`. A passive run of fewer than `EOF_T` samples never raises it.
- R4: Let `bus_i` be first sampled 1 at edge j. Then `idle_o` and `eof_o` both return to 0 after edge j+2.
- R5: Suppose the passive run before that rising sample lasted L samples, with `EOF_T` ≤ L < `IFS_T`, and `lock_o` was 0. Then `join_o` is 1 for exactly the one cycle after edge j+2. For any other L, `join_o` stays 0.
- R6: `sof_ok_o` is 1 exactly when `idle_o` or `join_o` is 1.
- R7: Let an active run start with the sample at edge j and last at least `BRK_T` samples. Then `brk_o` is 1 for exactly the one cycle after edge j+1+`BRK_T`. It pulses only once, however long the run lasts. A shorter active run produces no pulse.
- R8: `lock_o` rises together with `brk_o`. It falls in the same cycle that `idle_o` rises. While `lock_o` is 1, `join_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_i | input | 1 | Raw bus level, 1 = active, 0 = passive |
| idle_o | output | 1 | Inter-frame separation observed, held until the next rising edge |
| eof_o | output | 1 | End-of-frame minimum observed, held until the next rising edge |
| brk_o | output | 1 | One-cycle pulse when an active run reaches the break time |
| join_o | output | 1 | One-cycle late-join permission on a rising edge after the end-of-frame minimum |
| lock_o | output | 1 | Arbitration blocked after a break, until idle |
| sof_ok_o | output | 1 | A start-of-frame may be issued (idle or late join) |

## Verification
The bench sweeps every passive length from one sample up to three beyond the separation time. It pairs each with every active length from one sample up to two beyond the break time, so each boundary is hit exactly, one below and one above.

The two rising-edge cases are the most fragile:
- A passive run exactly at the end-of-frame minimum must grant a late join. A design with an off-by-one compare would miss it, and a skewed node would lose the arbitration.
- A run exactly at the separation time must grant idle instead of a join.

Active runs longer than the break time check two more faults:
- A pulse that repeats as the counter saturates.
- A late join that leaks through while the lock from a preceding break is still set.

// File: rtl/vpw_gap_pkg.sv
package vpw_gap_pkg;

  typedef struct packed {
    logic idle;
    logic eof;
    logic brk;
    logic join_ok;
    logic lock;
  } gap_flags_t;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/vpw_lvl_sync.sv
module vpw_lvl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_i,
  output logic lvl_o,
  output logic rise_o,
  output logic chg_o
);

  logic [STAGES-1:0] sh_q;
  logic              hist_q;

  // Resynchronising chain, bus level shifted in at the low end.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      hist_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], bus_i};
      hist_q <= sh_q[STAGES-1];
    end
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign rise_o = sh_q[STAGES-1] & ~hist_q;
  assign chg_o  = sh_q[STAGES-1] ^ hist_q;

endmodule

// File: rtl/vpw_run_timer.sv
module vpw_run_timer #(
  parameter int unsigned CNT_MAX = 300,
  parameter int unsigned CNT_W   = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chg_i,
  output logic [CNT_W-1:0] cnt_q_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);

  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(CNT_MAX);

  logic [CNT_W-1:0] cnt_q;

  // Length of the current run of the synchronised level, saturating.
  always_comb begin
    if (chg_i)               cnt_nxt_o = CNT_W'(1);
    else if (cnt_q == MAX_C) cnt_nxt_o = cnt_q;
    else                     cnt_nxt_o = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
  end

  assign cnt_q_o = cnt_q;

endmodule

// File: rtl/vpw_gap_flags.sv
module vpw_gap_flags
  import vpw_gap_pkg::*;
#(
  parameter int unsigned CNT_W = 9,
  parameter int unsigned EOF_T = 280,
  parameter int unsigned IFS_T = 300,
  parameter int unsigned BRK_T = 300
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] cnt_q_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  output gap_flags_t       flags_o
);

  localparam logic [CNT_W-1:0] EOF_C    = CNT_W'(EOF_T);
  localparam logic [CNT_W-1:0] IFS_C    = CNT_W'(IFS_T);
  localparam logic [CNT_W-1:0] BRK_C    = CNT_W'(BRK_T);
  localparam logic [CNT_W-1:0] BRK_PRE  = CNT_W'(BRK_T - 1);

  logic idle_q, eof_q, brk_q, join_q, lock_q;
  logic set_idle, set_eof, hit_brk, late_join;

  always_comb begin
    set_idle  = ~lvl_i & (cnt_nxt_i >= IFS_C) & ~idle_q;
    set_eof   = ~lvl_i & (cnt_nxt_i >= EOF_C) & ~eof_q;
    hit_brk   = lvl_i & (cnt_nxt_i == BRK_C) & (cnt_q_i == BRK_PRE);
    late_join = rise_i & eof_q & ~idle_q & ~lock_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= 1'b0;
      eof_q  <= 1'b0;
      brk_q  <= 1'b0;
      join_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      brk_q  <= hit_brk;
      join_q <= late_join;
      if (rise_i)        idle_q <= 1'b0;
      else if (set_idle) idle_q <= 1'b1;
      if (rise_i)        eof_q  <= 1'b0;
      else if (set_eof)  eof_q  <= 1'b1;
      if (hit_brk)       lock_q <= 1'b1;
      else if (set_idle) lock_q <= 1'b0;
    end
  end

  always_comb begin
    flags_o.idle    = idle_q;
    flags_o.eof     = eof_q;
    flags_o.brk     = brk_q;
    flags_o.join_ok = join_q;
    flags_o.lock    = lock_q;
  end

endmodule

// File: rtl/vpw_idle_brk_det.sv
module vpw_idle_brk_det
  import vpw_gap_pkg::*;
#(
  parameter int unsigned EOF_T       = 280,
  parameter int unsigned IFS_T       = 300,
  parameter int unsigned BRK_T       = 300,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_i,
  output logic idle_o,
  output logic eof_o,
  output logic brk_o,
  output logic join_o,
  output logic lock_o,
  output logic sof_ok_o
);

  localparam int unsigned CNT_MAX = max_of(IFS_T, BRK_T);
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  logic             lvl, rise, chg;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  gap_flags_t       flags;

  vpw_lvl_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bus_i  (bus_i),
    .lvl_o  (lvl),
    .rise_o (rise),
    .chg_o  (chg)
  );

  vpw_run_timer #(
    .CNT_MAX (CNT_MAX),
    .CNT_W   (CNT_W)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .chg_i     (chg),
    .cnt_q_o   (cnt_q),
    .cnt_nxt_o (cnt_nxt)
  );

  vpw_gap_flags #(
    .CNT_W (CNT_W),
    .EOF_T (EOF_T),
    .IFS_T (IFS_T),
    .BRK_T (BRK_T)
  ) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (lvl),
    .rise_i    (rise),
    .cnt_q_i   (cnt_q),
    .cnt_nxt_i (cnt_nxt),
    .flags_o   (flags)
  );

  assign idle_o   = flags.idle;
  assign eof_o    = flags.eof;
  assign brk_o    = flags.brk;
  assign join_o   = flags.join_ok;
  assign lock_o   = flags.lock;
  assign sof_ok_o = flags.idle | flags.join_ok;

endmodule

// File: rtl/vpw_idle_brk_chk.sv
module vpw_idle_brk_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic idle_o,
  input logic eof_o,
  input logic brk_o,
  input logic join_o,
  input logic lock_o
);

  p_brk_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |=> !brk_o);

  p_brk_locks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> lock_o);

  p_join_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    join_o |-> !$past(lock_o));

  p_join_after_eof_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    join_o |-> ($past(eof_o) && !$past(idle_o)));

  p_join_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    join_o |=> !join_o);

  p_idle_unlocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_o) |-> !lock_o);

  p_idle_needs_eof_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> eof_o);

endmodule

bind vpw_idle_brk_det vpw_idle_brk_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .idle_o (idle_o),
  .eof_o  (eof_o),
  .brk_o  (brk_o),
  .join_o (join_o),
  .lock_o (lock_o)
);

// File: tb/vpw_idle_brk_det_tb.sv
module vpw_idle_brk_det_tb;

  localparam int unsigned EOF_T = 5;
  localparam int unsigned IFS_T = 8;
  localparam int unsigned BRK_T = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus = 1'b0;
  logic idle_o, eof_o, brk_o, join_o, lock_o, sof_ok_o;

  int unsigned vecs = 0;
  int unsigned errs = 0;
  int unsigned cyc  = 0;
  bit cmp_en = 1'b0;
  bit done   = 1'b0;

  // reference model state (sample stream delayed by two edges)
  bit q1 = 1'b0, q2 = 1'b0, s_prev = 1'b0;
  int unsigned prun = 1000, arun = 0, lprev = 0;
  bit e_idle = 1'b0, e_eof = 1'b0, e_brk = 1'b0, e_join = 1'b0, e_lock = 1'b0, idle_prev = 1'b0;

  always #2 clk = ~clk;

  vpw_idle_brk_det #(
    .EOF_T (EOF_T),
    .IFS_T (IFS_T),
    .BRK_T (BRK_T)
  ) u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .bus_i    (bus),
    .idle_o   (idle_o),
    .eof_o    (eof_o),
    .brk_o    (brk_o),
    .join_o   (join_o),
    .lock_o   (lock_o),
    .sof_ok_o (sof_ok_o)
  );

  always @(posedge clk) begin
    bit s;
    bit first1;
    cyc++;
    s  = q2;
    q2 = q1;
    q1 = bus;
    first1 = s && !s_prev;
    if (first1) lprev = prun;
    if (s) begin
      if (arun < 1000) arun++;
      prun = 0;
    end else begin
      if (prun < 1000) prun++;
      arun = 0;
    end
    idle_prev = e_idle;
    e_idle = !s && (prun >= IFS_T);
    e_eof  = !s && (prun >= EOF_T);
    e_brk  = s && (arun == BRK_T);
    e_join = first1 && (lprev >= EOF_T) && (lprev < IFS_T) && !e_lock;
    if (e_brk)                      e_lock = 1'b1;
    else if (e_idle && !idle_prev)  e_lock = 1'b0;
    s_prev = s;
  end

  task automatic chk1(input string req, input string nm, input logic act,
                      input logic exp, inout bit bad);
    if (act !== exp) begin
      $display("FAIL %s %s: got %b expected %b at cycle %0d", req, nm, act, exp, cyc);
      bad = 1'b1;
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      bit bad;
      bad = 1'b0;
      vecs++;
      chk1("R2 R4", "idle_o",   idle_o,   e_idle,          bad);
      chk1("R3 R4", "eof_o",    eof_o,    e_eof,           bad);
      chk1("R7",    "brk_o",    brk_o,    e_brk,           bad);
      chk1("R5",    "join_o",   join_o,   e_join,          bad);
      chk1("R8",    "lock_o",   lock_o,   e_lock,          bad);
      chk1("R6",    "sof_ok_o", sof_ok_o, e_idle | e_join, bad);
      if (bad) errs++;
    end
  end

  task automatic drive(input logic v, input int unsigned n);
    bus = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    begin
      bit bad;
      bad = 1'b0;
      vecs++;
      chk1("R1", "idle_o",   idle_o,   1'b0, bad);
      chk1("R1", "eof_o",    eof_o,    1'b0, bad);
      chk1("R1", "brk_o",    brk_o,    1'b0, bad);
      chk1("R1", "join_o",   join_o,   1'b0, bad);
      chk1("R1", "lock_o",   lock_o,   1'b0, bad);
      chk1("R1", "sof_ok_o", sof_ok_o, 1'b0, bad);
      if (bad) errs++;
    end
    rst_n = 1'b1;
    repeat (IFS_T + 12) @(negedge clk);
    cmp_en = 1'b1;
    // Sweep every passive/active length pair across all thresholds (R2..R8)
    for (int a = 1; a <= int'(BRK_T) + 2; a++) begin
      for (int l = 1; l <= int'(IFS_T) + 3; l++) begin
        drive(1'b0, l);
        drive(1'b1, a);
      end
    end
    // Break, short gaps with late-join attempts while locked, then idle (R8)
    drive(1'b1, BRK_T + 4);
    drive(1'b0, EOF_T + 1);
    drive(1'b1, 2);
    drive(1'b0, IFS_T - 1);
    drive(1'b1, 2);
    drive(1'b0, IFS_T + 2);
    drive(1'b1, 3);
    drive(1'b0, EOF_T);
    drive(1'b1, 3);
    drive(1'b0, IFS_T + 4);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errs++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      finish_run();
    end
  end

endmodule